// File: doc/BRIEF.md
# Accumulator ALU with Packed Status Flags

This block is the arithmetic and logic core of a small accumulator machine. A single accumulator supplies the first operand of every operation. Each issued command brings an opcode and a second operand. The block captures the second operand in a hidden holding register. On the following clock edge it computes the result, writes it back to the accumulator when the operation calls for that, and refreshes an 8-bit status byte. The status byte holds sign, zero, half carry, even parity and carry flags.

The carry flag also acts as the carry-in for add-with-carry and as the borrow-in for subtract-with-borrow. Compare sets the flags as a subtract does but keeps the accumulator. Increment and decrement can target either the accumulator or the supplied operand. The operand forms leave the accumulator alone and return the new value on a separate result port, so that a register file outside the block can store it.

Top module: `alu8_acc_unit`

## Requirements
- R1: While reset is active and after it is released, the accumulator, status byte and result read 0, and done is low.
- R2: A command with issue_valid_i high at a rising edge is latched on that edge. The accumulator, status byte, result and done change on the next rising edge, and done is high for exactly that one cycle.
- R3: Opcode 0 (add) writes acc+operand. Opcode 1 (add with carry) writes acc+operand+CY. CY takes the carry out of bit 7, and opcode 0 ignores the old CY.
- R4: Opcode 2 (subtract) writes acc−operand. Opcode 3 (subtract with borrow) writes acc−operand−CY. CY is set when operand plus borrow-in exceeds the accumulator, and opcode 2 ignores the old CY.
- R5: Opcode 4 (compare) sets the status byte as opcode 2 would and shows the difference on result_o, but leaves the accumulator unchanged.
- R6: The half-carry flag (status bit 4) is set by add, add with carry and increment when the low nibbles produce a carry into bit 4. It is set by subtract, subtract with borrow, compare and decrement when the low nibble needs a borrow from bit 4. Logic operations clear it.
- R7: Status bit 7 copies result bit 7. Bit 6 is set when the result is zero. Bit 2 is set when the result has an even number of one bits. Bit 0 is the carry. Bits 5, 3 and 1 always read 0.
- R8: Opcodes 5 (increment accumulator) and 6 (decrement accumulator) write acc±1, update bits 7, 6, 4 and 2, and leave CY unchanged.
- R9: Opcodes 11 (increment operand) and 12 (decrement operand) put operand±1 on result_o, leave the accumulator unchanged, update bits 7, 6, 4 and 2 from that value, and leave CY unchanged.
- R10: Opcodes 7, 8 and 9 write the bitwise AND, OR and XOR of accumulator and operand, clear CY and the half carry, and recompute sign, zero and parity.
- R11: Opcode 10 writes the bitwise complement of the accumulator and leaves the status byte unchanged.
- R12: Opcodes 13, 14 and 15 change neither the accumulator nor the status byte; result_o shows the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid_i | input | 1 | A command is presented this cycle |
| issue_op_i | input | 4 | Operation code |
| issue_opnd_i | input | WIDTH | Second operand |
| acc_o | output | WIDTH | Accumulator contents |
| status_o | output | 8 | Packed status byte |
| result_o | output | WIDTH | Value computed by the last command |
| done_o | output | 1 | One-cycle pulse when a command completes |

## Verification
The two-operand operations are swept over a grid of sixteen accumulator values and thirty-two operand values. The grid includes 0, 0x0F-style nibble edges, 0x80 and 0xFF, and each pair runs with the incoming carry both clear and set. This separates correct carry and borrow chaining from a carry-in that is wrongly applied to plain add or subtract. It also separates nibble carries from byte carries, because the half-carry and carry outcomes vary independently across the grid. Increment, decrement and complement run over all 256 accumulator values, and the operand forms over all 256 operands. These sweeps catch wrap-around at 0x00 and 0xFF, a carry flag that is wrongly altered, and an accumulator that is wrongly written. A timed command confirms the one-cycle latency through the holding register.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int OP_W = 4;
    localparam int ST_W = 8;

    // status byte bit positions
    localparam int ST_S  = 7;
    localparam int ST_Z  = 6;
    localparam int ST_AC = 4;
    localparam int ST_P  = 2;
    localparam int ST_CY = 0;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBB  = 4'd3,
        OP_CMP  = 4'd4,
        OP_INCA = 4'd5,
        OP_DECA = 4'd6,
        OP_AND  = 4'd7,
        OP_OR   = 4'd8,
        OP_XOR  = 4'd9,
        OP_CMA  = 4'd10,
        OP_INCB = 4'd11,
        OP_DECB = 4'd12,
        OP_RSV0 = 4'd13,
        OP_RSV1 = 4'd14,
        OP_RSV2 = 4'd15
    } op_e;

    function automatic logic [ST_W-1:0] pack_status(
        input logic s, input logic z, input logic ac,
        input logic p, input logic cy);
        logic [ST_W-1:0] v;
        v        = '0;
        v[ST_S]  = s;
        v[ST_Z]  = z;
        v[ST_AC] = ac;
        v[ST_P]  = p;
        v[ST_CY] = cy;
        return v;
    endfunction

    function automatic logic is_incdec(input op_e op);
        return (op == OP_INCA) || (op == OP_DECA) ||
               (op == OP_INCB) || (op == OP_DECB);
    endfunction

    function automatic logic is_logic(input op_e op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    endfunction

    function automatic logic is_reserved(input op_e op);
        return (op == OP_RSV0) || (op == OP_RSV1) || (op == OP_RSV2);
    endfunction

endpackage

// File: rtl/alu8_opnd_latch.sv
module alu8_opnd_latch
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  op_e              in_op,
    input  logic [WIDTH-1:0] in_opnd,
    output logic             ex_valid,
    output op_e              ex_op,
    output logic [WIDTH-1:0] ex_opnd
);

    typedef struct packed {
        logic             valid;
        op_e              op;
        logic [WIDTH-1:0] opnd;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d       = hold_q;
        hold_d.valid = in_valid;
        if (in_valid) begin
            hold_d.op   = in_op;
            hold_d.opnd = in_opnd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign ex_valid = hold_q.valid;
    assign ex_op    = hold_q.op;
    assign ex_opnd  = hold_q.opnd;

endmodule

// File: rtl/alu8_split_adder.sv
module alu8_split_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             c_half,
    output logic             c_out
);

    localparam int HALF  = WIDTH / 2;
    localparam int UPPER = WIDTH - HALF;

    logic [HALF:0]  lo;
    logic [UPPER:0] hi;

    always_comb begin
        lo = {1'b0, x[HALF-1:0]} + {1'b0, y[HALF-1:0]} + {{HALF{1'b0}}, cin};
        hi = {1'b0, x[WIDTH-1:HALF]} + {1'b0, y[WIDTH-1:HALF]}
           + {{UPPER{1'b0}}, lo[HALF]};
    end

    assign sum    = {hi[UPPER-1:0], lo[HALF-1:0]};
    assign c_half = lo[HALF];
    assign c_out  = hi[UPPER];

endmodule

// File: rtl/alu8_exec.sv
module alu8_exec
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  op_e              op,
    input  logic [WIDTH-1:0] acc,
    input  logic [WIDTH-1:0] opnd,
    input  logic [ST_W-1:0]  st_in,
    output logic [WIDTH-1:0] res,
    output logic [ST_W-1:0]  st_out,
    output logic             acc_we
);

    logic [WIDTH-1:0] add_x, add_y, add_sum, lg;
    logic             add_ci, is_sub, add_ch, add_co;
    logic             cy_a, ac_a;
    logic             cy_old;

    assign cy_old = st_in[ST_CY];

    function automatic logic even_par(input logic [WIDTH-1:0] v);
        logic acc_p;
        acc_p = 1'b1;
        for (int i = 0; i < WIDTH; i++) begin
            acc_p = acc_p ^ v[i];
        end
        return acc_p;
    endfunction

    // operand steering into the shared adder
    always_comb begin
        add_x  = acc;
        add_y  = opnd;
        add_ci = 1'b0;
        is_sub = 1'b0;
        unique case (op)
            OP_ADC: add_ci = cy_old;
            OP_SUB, OP_CMP: begin
                add_y  = ~opnd;
                add_ci = 1'b1;
                is_sub = 1'b1;
            end
            OP_SBB: begin
                add_y  = ~opnd;
                add_ci = ~cy_old;
                is_sub = 1'b1;
            end
            OP_INCA: begin
                add_y  = '0;
                add_ci = 1'b1;
            end
            OP_DECA: begin
                add_y  = '1;
                is_sub = 1'b1;
            end
            OP_INCB: begin
                add_x  = opnd;
                add_y  = '0;
                add_ci = 1'b1;
            end
            OP_DECB: begin
                add_x  = opnd;
                add_y  = '1;
                is_sub = 1'b1;
            end
            default: ;
        endcase
    end

    alu8_split_adder #(.WIDTH(WIDTH)) adder_i (
        .x      (add_x),
        .y      (add_y),
        .cin    (add_ci),
        .sum    (add_sum),
        .c_half (add_ch),
        .c_out  (add_co)
    );

    // a missing carry in two's complement subtraction means a borrow
    assign cy_a = is_sub ? ~add_co : add_co;
    assign ac_a = is_sub ? ~add_ch : add_ch;

    always_comb begin
        unique case (op)
            OP_AND:  lg = acc & opnd;
            OP_OR:   lg = acc | opnd;
            default: lg = acc ^ opnd;
        endcase
    end

    always_comb begin
        res    = acc;
        st_out = st_in;
        acc_we = 1'b0;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
                res    = add_sum;
                acc_we = 1'b1;
                st_out = pack_status(add_sum[WIDTH-1], add_sum == '0, ac_a,
                                     even_par(add_sum), cy_a);
            end
            OP_CMP: begin
                res    = add_sum;
                st_out = pack_status(add_sum[WIDTH-1], add_sum == '0, ac_a,
                                     even_par(add_sum), cy_a);
            end
            OP_INCA, OP_DECA, OP_INCB, OP_DECB: begin
                res    = add_sum;
                acc_we = (op == OP_INCA) || (op == OP_DECA);
                st_out = pack_status(add_sum[WIDTH-1], add_sum == '0, ac_a,
                                     even_par(add_sum), cy_old);
            end
            OP_AND, OP_OR, OP_XOR: begin
                res    = lg;
                acc_we = 1'b1;
                st_out = pack_status(lg[WIDTH-1], lg == '0, 1'b0,
                                     even_par(lg), 1'b0);
            end
            OP_CMA: begin
                res    = ~acc;
                acc_we = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/alu8_acc_unit.sv
module alu8_acc_unit
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_valid_i,
    input  logic [3:0]       issue_op_i,
    input  logic [WIDTH-1:0] issue_opnd_i,
    output logic [WIDTH-1:0] acc_o,
    output logic [7:0]       status_o,
    output logic [WIDTH-1:0] result_o,
    output logic             done_o
);

    typedef struct packed {
        logic [WIDTH-1:0] acc;
        logic [ST_W-1:0]  status;
        logic [WIDTH-1:0] result;
        logic             done;
    } state_t;

    state_t st_d, st_q;

    logic             ex_valid;
    op_e              ex_op;
    logic [WIDTH-1:0] ex_opnd;
    logic [WIDTH-1:0] ex_res;
    logic [ST_W-1:0]  ex_st;
    logic             ex_we;

    alu8_opnd_latch #(.WIDTH(WIDTH)) latch_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (issue_valid_i),
        .in_op    (op_e'(issue_op_i)),
        .in_opnd  (issue_opnd_i),
        .ex_valid (ex_valid),
        .ex_op    (ex_op),
        .ex_opnd  (ex_opnd)
    );

    alu8_exec #(.WIDTH(WIDTH)) exec_i (
        .op     (ex_op),
        .acc    (st_q.acc),
        .opnd   (ex_opnd),
        .st_in  (st_q.status),
        .res    (ex_res),
        .st_out (ex_st),
        .acc_we (ex_we)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = ex_valid;
        if (ex_valid) begin
            st_d.result = ex_res;
            st_d.status = ex_st;
            if (ex_we) begin
                st_d.acc = ex_res;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o    = st_q.acc;
    assign status_o = st_q.status;
    assign result_o = st_q.result;
    assign done_o   = st_q.done;

    // ---------------------------------------------------------------
    // assertions
    // ---------------------------------------------------------------
    assert_done_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid |=> done_o);

    assert_cmp_keeps_acc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_op == OP_CMP) |=> $stable(acc_o));

    assert_unused_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[5] == 1'b0) && (status_o[3] == 1'b0) && (status_o[1] == 1'b0));

    assert_incdec_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && is_incdec(ex_op)) |=> $stable(status_o[ST_CY]));

    assert_opnd_incdec_acc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && (ex_op == OP_INCB || ex_op == OP_DECB)) |=> $stable(acc_o));

    assert_logic_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && is_logic(ex_op)) |=> (!status_o[ST_CY] && !status_o[ST_AC]));

    assert_cma_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_op == OP_CMA) |=> $stable(status_o));

    assert_reserved_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && is_reserved(ex_op)) |=> ($stable(acc_o) && $stable(status_o)));

endmodule

// File: tb/alu8_acc_unit_tb.sv
module alu8_acc_unit_tb_top;

    localparam logic [3:0] C_ADD = 4'd0, C_ADC = 4'd1, C_SUB = 4'd2, C_SBB = 4'd3,
                           C_CMP = 4'd4, C_INCA = 4'd5, C_DECA = 4'd6, C_AND = 4'd7,
                           C_OR = 4'd8, C_XOR = 4'd9, C_CMA = 4'd10, C_INCB = 4'd11,
                           C_DECB = 4'd12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       valid = 1'b0;
    logic [3:0] op = '0;
    logic [7:0] opnd = '0;
    logic [7:0] acc_o, status_o, result_o;
    logic       done_o;

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    alu8_acc_unit #(.WIDTH(8)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .issue_valid_i (valid),
        .issue_op_i    (op),
        .issue_opnd_i  (opnd),
        .acc_o         (acc_o),
        .status_o      (status_o),
        .result_o      (result_o),
        .done_o        (done_o)
    );

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    function automatic int exp_st(input int r, input int ac, input int cy);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
        return ((r >> 7) & 1) * 128 + (r == 0 ? 64 : 0) + (ac != 0 ? 16 : 0)
             + ((ones % 2) == 0 ? 4 : 0) + (cy != 0 ? 1 : 0);
    endfunction

    task automatic issue(input logic [3:0] o, input int b);
        @(negedge clk);
        valid = 1'b1;
        op    = o;
        opnd  = b[7:0];
        @(negedge clk);
        valid = 1'b0;
        @(negedge clk);
    endtask

    // accumulator = a, carry = cy
    task automatic set_acc(input int a, input int cy);
        issue(C_AND, 0);
        if (cy == 0 || a != 255) begin
            issue(C_ADD, a);
            if (cy != 0) issue(C_CMP, 255);
        end else begin
            issue(C_ADD, 254);
            issue(C_CMP, 255);
            issue(C_INCA, 0);
        end
    endtask

    task automatic run_arith(input logic [3:0] o, input int a, input int b, input int c);
        int r, ac, cy, acc_e;
        string tag;
        set_acc(a, c);
        issue(o, b);
        case (o)
            C_ADD, C_ADC: begin
                int ci = (o == C_ADC) ? c : 0;
                r  = (a + b + ci) & 255;
                cy = (a + b + ci) > 255;
                ac = ((a & 15) + (b & 15) + ci) > 15;
                tag = "R3";
            end
            C_SUB, C_SBB, C_CMP: begin
                int bi = (o == C_SBB) ? c : 0;
                r  = (a - b - bi) & 255;
                cy = (b + bi) > a;
                ac = ((b & 15) + bi) > (a & 15);
                tag = (o == C_CMP) ? "R5" : "R4";
            end
            default: begin
                r  = (o == C_AND) ? (a & b) : (o == C_OR) ? (a | b) : (a ^ b);
                cy = 0;
                ac = 0;
                tag = "R10";
            end
        endcase
        acc_e = (o == C_CMP) ? a : r;
        chk({tag, " acc"}, acc_o, acc_e);
        chk({tag, " result"}, result_o, r);
        chk("R6 half carry", status_o[4], ac);
        chk({tag, " R7 status"}, status_o, exp_st(r, ac, cy));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 acc in reset", acc_o, 0);
        chk("R1 status in reset", status_o, 0);
        chk("R1 done in reset", done_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 acc after reset", acc_o, 0);
        chk("R1 result after reset", result_o, 0);

        // R2: latency
        set_acc(16, 0);
        @(negedge clk);
        valid = 1'b1; op = C_ADD; opnd = 8'h01;
        @(negedge clk);
        valid = 1'b0;
        chk("R2 acc before exec", acc_o, 16);
        chk("R2 done before exec", done_o, 0);
        @(negedge clk);
        chk("R2 acc after exec", acc_o, 17);
        chk("R2 done pulse", done_o, 1);
        @(negedge clk);
        chk("R2 done drops", done_o, 0);

        // two-operand grid
        for (int ia = 0; ia < 16; ia++) begin
            for (int jb = 0; jb < 32; jb++) begin
                int a = ia * 17;
                int b = jb * 8 + (jb & 7);
                int c = jb & 1;
                run_arith(C_ADD, a, b, c);
                run_arith(C_ADC, a, b, 0);
                run_arith(C_ADC, a, b, 1);
                run_arith(C_SUB, a, b, 1 - c);
                run_arith(C_SBB, a, b, 0);
                run_arith(C_SBB, a, b, 1);
                run_arith(C_CMP, a, b, c);
                run_arith(C_AND, a, b, c);
                run_arith(C_OR, a, b, 1 - c);
                run_arith(C_XOR, a, b, c);
            end
        end

        // accumulator increment, decrement, complement
        for (int a = 0; a < 256; a++) begin
            for (int c = 0; c < 2; c++) begin
                int r;
                logic [7:0] st_before;
                set_acc(a, c);
                issue(C_INCA, 0);
                r = (a + 1) & 255;
                chk("R8 inc acc", acc_o, r);
                chk("R6 inc half carry", status_o[4], (a & 15) == 15);
                chk("R8 inc status", status_o, exp_st(r, (a & 15) == 15, c));
                set_acc(a, c);
                issue(C_DECA, 0);
                r = (a + 255) & 255;
                chk("R8 dec acc", acc_o, r);
                chk("R8 dec status", status_o, exp_st(r, (a & 15) == 0, c));
                set_acc(a, c);
                st_before = status_o;
                issue(C_CMA, 0);
                chk("R11 complement acc", acc_o, (~a) & 255);
                chk("R11 status kept", status_o, st_before);
            end
        end

        // operand increment and decrement
        for (int b = 0; b < 256; b++) begin
            int c = b & 1;
            int r;
            set_acc(90, c);
            issue(C_INCB, b);
            r = (b + 1) & 255;
            chk("R9 inc result", result_o, r);
            chk("R9 inc acc kept", acc_o, 90);
            chk("R9 inc status", status_o, exp_st(r, (b & 15) == 15, c));
            issue(C_DECB, b);
            r = (b + 255) & 255;
            chk("R9 dec result", result_o, r);
            chk("R9 dec acc kept", acc_o, 90);
            chk("R9 dec status", status_o, exp_st(r, (b & 15) == 0, c));
        end

        // reserved codes
        set_acc(60, 1);
        for (int code = 13; code < 16; code++) begin
            logic [7:0] st_before;
            st_before = status_o;
            issue(code[3:0], 255);
            chk("R12 acc kept", acc_o, 60);
            chk("R12 status kept", status_o, st_before);
            chk("R12 result shows acc", result_o, 60);
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule